// File: doc/BRIEF.md
# Stack Pointer Unit with Limit and Floor Trap

This block holds the software stack pointer of a 16-bit processor whose data memory is byte-addressed and word-aligned. The stack grows upward, and the pointer always holds the address of the next free word. A push stores a word at the pointer and then adds two. A pop subtracts two and then loads from the new address. For each access the block drives the effective address and a write or read strobe toward data memory in the same cycle as the request. The pointer takes its new value at the clock edge that ends that cycle.

Two bounds guard the stack. The first is an upper limit held in a register that software programs. A write that lands exactly on the limit is allowed, and a write above it traps. The second is a fixed floor: any stack access below it traps, which keeps the stack out of the register area underneath. A trap is a one-cycle pulse. It also sets a flag that stays high until software clears it. The access that caused the trap still completes.

The block also builds call frames. A call frame is two words pushed in back-to-back cycles. The first word is the low 16 bits of the program counter. The second word holds the upper program-counter bits and has its MSB clear. In an exception frame, the second word also carries the low status byte.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, `sp_o` is 0x0800 and `trap_o`, `err_o` and `busy_o` are all 0.
- R2: An accepted push drives `mem_we_o`=1 with `ea_o` equal to `sp_o` and `mem_wdata_o` equal to `push_data_i` in the same cycle. `sp_o` increases by 2 at the next edge.
- R3: An accepted pop drives `mem_re_o`=1 with `ea_o` equal to `sp_o`-2 in the same cycle. `sp_o` decreases by 2 at the next edge.
- R4: A pointer write through `sp_we_i` loads `sp_wdata_i` with bit 0 forced to 0. `sp_o` is always even, and so is every `ea_o` that comes with a strobe.
- R5: A stack write whose `ea_o` is unsigned-greater than the limit raises the trap. A write whose `ea_o` equals the limit does not. Pops never raise the overflow trap. Bit 0 of the stored limit is forced to 0.
- R6: A push or pop whose `ea_o` is unsigned-below 0x0800 raises the trap. The offending access still updates `sp_o`.
- R7: `trap_o` is a one-cycle pulse in the cycle after the offending access. At the same edge `err_o` is set, and it stays set until `err_clr_i` is applied. If a new trap and `err_clr_i` fall in the same cycle, the flag stays set.
- R8: A limit written in cycle N is used for accesses from cycle N+1 onward. A push in cycle N is judged against the old limit.
- R9: `call_i` pushes PC[15:0] at `sp_o` in its cycle. In the following cycle, with `busy_o`=1, it pushes {9'b0, PC[22:16]} at `sp_o`+2. `sp_o` ends 4 higher.
- R10: `exc_i` builds the same frame, except that the second word is {SR[7:0], 1'b0, PC[22:16]}.
- R11: Priority runs from highest to lowest: `sp_we_i`, then `exc_i`, then `call_i`, then `push_i`, then `pop_i`. A strobe that loses causes no access.
- R12: While `busy_o`=1, `push_i`, `pop_i`, `call_i`, `exc_i` and `sp_we_i` have no effect.
- R13: Pointer arithmetic wraps within 16 bits. A push at 0xFFFE leaves `sp_o` at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push one data word |
| pop_i | input | 1 | Pop one word |
| call_i | input | 1 | Push a two-word call frame |
| exc_i | input | 1 | Push a two-word exception frame |
| push_data_i | input | 16 | Data for a plain push |
| pc_i | input | 23 | Program counter for a frame |
| sr_i | input | 8 | Low status byte for an exception frame |
| sp_we_i | input | 1 | Pointer write strobe |
| sp_wdata_i | input | 16 | Pointer write data |
| lim_we_i | input | 1 | Limit register write strobe |
| lim_wdata_i | input | 16 | Limit register write data |
| err_clr_i | input | 1 | Clears the sticky error flag |
| sp_o | output | 16 | Current stack pointer |
| ea_o | output | 16 | Effective address of the current access |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 16 | Memory write data |
| busy_o | output | 1 | High during the second cycle of a frame |
| trap_o | output | 1 | Stack error pulse |
| err_o | output | 1 | Sticky stack error flag |

## Verification
A limit write and a push can occur in the same cycle. This is the allowed one-cycle hazard. The bench parks the pointer on the old limit plus two, then raises `lim_we_i` with a higher limit and `push_i` together. The access in that cycle must trap against the old limit, and the push that follows must not trap. A trap and an error clear are also driven into the same cycle, and the flag is expected to stay set.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int          AW     = 16,
  parameter int          PCW    = 23,
  parameter int          SRW    = 8,
  parameter logic [15:0] FLOOR  = 16'h0800,
  parameter logic [15:0] SP_RST = 16'h0800
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic           call_i,
  input  logic           exc_i,
  input  logic [AW-1:0]  push_data_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [SRW-1:0] sr_i,
  input  logic           sp_we_i,
  input  logic [AW-1:0]  sp_wdata_i,
  input  logic           lim_we_i,
  input  logic [AW-1:0]  lim_wdata_i,
  input  logic           err_clr_i,
  output logic [AW-1:0]  sp_o,
  output logic [AW-1:0]  ea_o,
  output logic           mem_we_o,
  output logic           mem_re_o,
  output logic [AW-1:0]  mem_wdata_o,
  output logic           busy_o,
  output logic           trap_o,
  output logic           err_o
);
  localparam int HIW = PCW - AW;
  localparam int PAD = AW - SRW - HIW;
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] sp_q, lim_q, hi_q;
  logic          busy_q, trap_q, err_q;

  logic idle, frame, do_push, do_pop, ovf, udf, hit;
  logic [AW-1:0] hi_word;

  assign idle    = !busy_q && !sp_we_i;
  assign frame   = idle && (call_i || exc_i);
  assign do_push = idle && (call_i || exc_i || push_i);
  assign do_pop  = idle && pop_i && !(call_i || exc_i || push_i);

  assign hi_word = exc_i ? {sr_i, {PAD{1'b0}}, pc_i[PCW-1:AW]}
                         : {{(SRW+PAD){1'b0}}, pc_i[PCW-1:AW]};

  assign mem_we_o    = busy_q || do_push;
  assign mem_re_o    = do_pop;
  assign ea_o        = do_pop ? sp_q - STEP : sp_q;
  assign mem_wdata_o = busy_q ? hi_q : (frame ? pc_i[AW-1:0] : push_data_i);

  assign ovf = mem_we_o && (ea_o > lim_q);
  assign udf = (mem_we_o || mem_re_o) && (ea_o < FLOOR);
  assign hit = ovf || udf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= SP_RST;
      busy_q <= 1'b0;
      hi_q   <= '0;
      trap_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (busy_q || do_push)  sp_q <= sp_q + STEP;
      else if (sp_we_i)       sp_q <= {sp_wdata_i[AW-1:1], 1'b0};
      else if (do_pop)        sp_q <= sp_q - STEP;
      busy_q <= frame;
      if (frame) hi_q <= hi_word;
      trap_q <= hit;
      err_q  <= hit || (err_q && !err_clr_i);
    end
  end

  always_ff @(posedge clk) begin
    if (lim_we_i) lim_q <= {lim_wdata_i[AW-1:1], 1'b0};
  end

  assign sp_o   = sp_q;
  assign busy_o = busy_q;
  assign trap_o = trap_q;
  assign err_o  = err_q;
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        push_i,
  input logic        pop_i,
  input logic        call_i,
  input logic        exc_i,
  input logic        sp_we_i,
  input logic [15:0] sp_o,
  input logic [15:0] ea_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic        busy_o,
  input logic        trap_o,
  input logic        err_o
);
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !call_i && !exc_i && !busy_o && !sp_we_i) |=> (sp_o == $past(sp_o) + 16'd2));

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !call_i && !exc_i && !busy_o && !sp_we_i) |=> (sp_o == $past(sp_o) - 16'd2));

  assert_sp_even_R4: assert property (@(posedge clk) disable iff (!rst_n) !sp_o[0]);

  assert_ea_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) |-> !ea_o[0]);

  assert_trap_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n) trap_o |-> err_o);

  assert_busy_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> !busy_o);

  assert_busy_writes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (mem_we_o && !mem_re_o));
endmodule

bind stack_ptr_unit stack_ptr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
  .exc_i(exc_i), .sp_we_i(sp_we_i), .sp_o(sp_o), .ea_o(ea_o),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .busy_o(busy_o),
  .trap_o(trap_o), .err_o(err_o)
);

// File: tb/tb_stack_ptr_unit.sv
`timescale 1ns/1ps
module tb_stack_ptr_unit;
  logic clk = 0, rst_n = 0;
  logic push_i = 0, pop_i = 0, call_i = 0, exc_i = 0;
  logic [15:0] push_data_i = 0, sp_wdata_i = 0, lim_wdata_i = 0;
  logic [22:0] pc_i = 0;
  logic [7:0]  sr_i = 0;
  logic sp_we_i = 0, lim_we_i = 0, err_clr_i = 0;
  logic [15:0] sp_o, ea_o, mem_wdata_o;
  logic mem_we_o, mem_re_o, busy_o, trap_o, err_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  stack_ptr_unit dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    push_i = 0; pop_i = 0; call_i = 0; exc_i = 0;
    sp_we_i = 0; lim_we_i = 0; err_clr_i = 0;
  endtask

  task automatic step();
    @(posedge clk); #0.5; idle_in();
  endtask

  task automatic set_sp(logic [15:0] v);
    @(negedge clk); sp_we_i = 1; sp_wdata_i = v; step();
  endtask

  task automatic set_lim(logic [15:0] v);
    @(negedge clk); lim_we_i = 1; lim_wdata_i = v; step();
  endtask

  // op: 0 push, 1 pop ; fields {op, data, exp_ea, exp_sp, exp_trap}
  localparam int NV = 6;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 16'h1111, 16'h0BFA, 16'h0BFC, 1'b0},
    {1'b0, 16'h2222, 16'h0BFC, 16'h0BFE, 1'b0},
    {1'b0, 16'h3333, 16'h0BFE, 16'h0C00, 1'b0},
    {1'b0, 16'h4444, 16'h0C00, 16'h0C02, 1'b1},
    {1'b1, 16'h0000, 16'h0C00, 16'h0C00, 1'b0},
    {1'b1, 16'h0000, 16'h0BFE, 16'h0BFE, 1'b0}
  };

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5; rst_n = 1;
    @(negedge clk);
    chk("R1 sp", sp_o, 16'h0800); chk("R1 trap", trap_o, 0);
    chk("R1 err", err_o, 0);      chk("R1 busy", busy_o, 0);

    set_lim(16'h0BFF);  // stored as 0x0BFE (R5)
    set_sp(16'h0BFB);   // stored as 0x0BFA (R4)
    chk("R4 sp write bit0", sp_o, 16'h0BFA);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (VEC[i][49]) pop_i = 1; else begin push_i = 1; push_data_i = VEC[i][48:33]; end
      #0.5;
      chk("R2/R3 ea", ea_o, VEC[i][32:17]);
      chk("R2/R3 we", mem_we_o, !VEC[i][49]);
      chk("R2/R3 re", mem_re_o, VEC[i][49]);
      if (!VEC[i][49]) chk("R2 wdata", mem_wdata_o, VEC[i][48:33]);
      step();
      chk("R2/R3 sp", sp_o, VEC[i][16:1]);
      chk("R5 trap", trap_o, VEC[i][0]);
    end
    chk("R7 err sticky", err_o, 1);
    @(negedge clk); err_clr_i = 1; step();
    chk("R7 err clear", err_o, 0);
    chk("R7 trap pulse", trap_o, 0);

    // R6 underflow on pop and push
    set_sp(16'h0800);
    @(negedge clk); pop_i = 1; #0.5; chk("R6 pop ea", ea_o, 16'h07FE); step();
    chk("R6 pop trap", trap_o, 1); chk("R6 sp updated", sp_o, 16'h07FE);
    @(negedge clk); push_i = 1; step();
    chk("R6 push trap", trap_o, 1); chk("R6 push sp", sp_o, 16'h0800);

    // R7 set wins over clear
    set_sp(16'h0C00);
    @(negedge clk); push_i = 1; err_clr_i = 1; step();
    chk("R7 set beats clear", err_o, 1);
    @(negedge clk); err_clr_i = 1; step();

    // R8 limit write hazard
    set_sp(16'h0C00);
    @(negedge clk); push_i = 1; lim_we_i = 1; lim_wdata_i = 16'h0FFE; step();
    chk("R8 old limit used", trap_o, 1);
    @(negedge clk); push_i = 1; step();
    chk("R8 new limit used", trap_o, 0);
    chk("R8 sp", sp_o, 16'h0C04);

    // R9 call frame, with R12 strobes held during busy
    set_sp(16'h0900);
    @(negedge clk); call_i = 1; pc_i = 23'h5A1234; #0.5;
    chk("R9 word1 ea", ea_o, 16'h0900); chk("R9 word1", mem_wdata_o, 16'h1234);
    @(posedge clk); #0.5; call_i = 0; push_i = 1; sp_we_i = 1; sp_wdata_i = 16'h2000; pop_i = 1;
    chk("R9 busy", busy_o, 1); chk("R9 word2 ea", ea_o, 16'h0902);
    chk("R9 word2", mem_wdata_o, 16'h005A); chk("R12 no read", mem_re_o, 0);
    step();
    chk("R12 sp after frame", sp_o, 16'h0904); chk("R9 busy end", busy_o, 0);

    // R10 exception frame, R11 exc beats call
    @(negedge clk); exc_i = 1; call_i = 1; pc_i = 23'h7F0001; sr_i = 8'hA5; #0.5;
    chk("R11 exc word1", mem_wdata_o, 16'h0001);
    step(); #0.1;
    chk("R10 word2", mem_wdata_o, 16'hA57F);
    step();
    chk("R10 sp", sp_o, 16'h0908);

    // R11 push over pop, sp write over push
    @(negedge clk); push_i = 1; pop_i = 1; push_data_i = 16'hBEEF; #0.5;
    chk("R11 push wins", mem_we_o, 1); chk("R11 no pop", mem_re_o, 0); step();
    chk("R11 sp", sp_o, 16'h090A);
    @(negedge clk); push_i = 1; sp_we_i = 1; sp_wdata_i = 16'h0A00; #0.5;
    chk("R11 sp_we no access", mem_we_o, 0); step();
    chk("R11 sp_we wins", sp_o, 16'h0A00);

    // R13 wrap
    set_sp(16'hFFFE);
    @(negedge clk); push_i = 1; step();
    chk("R13 wrap", sp_o, 16'h0000); chk("R13 trap", trap_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule